// File: doc/BRIEF.md
# Jack-Detect Output Enable Gate

This block decides which of four audio output drivers, and whether the mid-rail reference, may be powered. It uses the level of one of three general-purpose input pins as a jack-presence signal. Each pin passes through a two-flop synchroniser. A two-bit select picks one of the synchronised pins, and that pin's level is debounced into a settled detect level.

When detection is switched on, the settled level chooses between two programmable four-bit masks. The chosen mask is ANDed with the normal per-output enables. The reference-enable bit for the same level is ORed with the normal reference enable. When detection is switched off, the mask acts as all ones and the reference bits have no effect, so the normal enables pass through unchanged.

Every signal on this block is a static control or status level. There is no data stream, so no port has a valid/ready handshake and the block never applies back-pressure. Both outputs are registered.

Top module: `jd_gate`

## Requirements
- R1: While `rst` is high at a clock edge, `out_en_o` becomes 0 and `ref_en_o` becomes 0 after that edge, and the settled detect level is cleared to 0.
- R2: When `det_on` is 0 at a clock edge, after that edge `out_en_o` equals `out_en_req` and `ref_en_o` equals `ref_req`, both as sampled at that edge. The pins, masks and reference bits have no effect.
- R3: `det_sel` = 2'b00 selects `pin_i[0]`, 2'b01 selects `pin_i[1]`, and 2'b10 selects `pin_i[2]` as the detect source.
- R4: `det_sel` = 2'b11 is reserved and behaves as if the detect level were 0, whatever the pins are.
- R5: With detection on and a settled level of 0, bit k of `out_en_o` is `out_en_req[k] & mask_lo[k]` for k = 0..3, where bit k drives output k+1.
- R6: With detection on and a settled level of 1, bit k of `out_en_o` is `out_en_req[k] & mask_hi[k]`.
- R7: With detection on, `ref_en_o` is `ref_req` OR `ref_lo` when the level is 0, and `ref_req` OR `ref_hi` when the level is 1. When both reference bits are 0, `ref_en_o` follows `ref_req`.
- R8: The settled level takes a new value only after the selected synchronised input has differed from it for DB_CYCLES consecutive cycles (default 4). With the default, a pin pulse of 3 cycles is ignored and a pulse of 4 cycles is adopted.
- R9: A change on a pin cannot reach the outputs sooner than 2 synchroniser cycles plus DB_CYCLES plus 1 output cycle. With the default this is 7 cycles, so the outputs are still unchanged 3 cycles after the pin moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 3 | Asynchronous general-purpose input pins |
| det_sel | input | 2 | Detect source select (11 reserved) |
| det_on | input | 1 | Jack detection enable |
| mask_lo | input | 4 | Output mask used when the detect level is 0 |
| mask_hi | input | 4 | Output mask used when the detect level is 1 |
| ref_lo | input | 1 | Reference enable added when the detect level is 0 |
| ref_hi | input | 1 | Reference enable added when the detect level is 1 |
| out_en_req | input | 4 | Normal per-output enables |
| ref_req | input | 1 | Normal reference enable |
| out_en_o | output | 4 | Final output-driver enables |
| ref_en_o | output | 1 | Final reference enable |

## Verification
The assertions check four things on every cycle: the reset values, pass-through when detection is off, that no driver is ever enabled without its normal request, and that a reference request is always honoured. The following can only be shown by the bench's scenarios, because each depends on pin history over several cycles:
- which mask the settled level selects;
- how the reserved select is handled;
- the debounce threshold at 3 versus 4 cycles;
- the minimum latency from a pin change to the outputs.

// File: rtl/jdg_pkg.sv
package jdg_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } det_lvl_e;

  localparam int DEF_DB_CYCLES = 4;
endpackage

// File: rtl/jdg_sync.sv
module jdg_sync #(
  parameter int N_PINS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_a,
  output logic [N_PINS-1:0] pin_s
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= pin_a[g];
        sync_q <= meta_q;
      end
    end
    assign pin_s[g] = sync_q;
  end
endmodule

// File: rtl/jdg_debounce.sv
module jdg_debounce
  import jdg_pkg::*;
#(
  parameter int N_PINS    = 3,
  parameter int SEL_W     = 2,
  parameter int DB_CYCLES = DEF_DB_CYCLES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_s,
  input  logic [SEL_W-1:0]  sel,
  output det_lvl_e          lvl_o
);
  localparam int CNT_W = $clog2(DB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

  logic           raw_lvl;
  logic [CNT_W-1:0] cnt_q;
  det_lvl_e       lvl_q;

  // Pick the selected pin; any unused select code reads as level 0.
  always_comb begin
    raw_lvl = 1'b0;
    for (int i = 0; i < N_PINS; i++) begin
      if (sel == SEL_W'(i)) raw_lvl = pin_s[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl_q <= LVL_LO;
    end else if (raw_lvl == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      lvl_q <= det_lvl_e'(raw_lvl);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/jdg_gate_out.sv
module jdg_gate_out
  import jdg_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  det_lvl_e         lvl,
  input  logic             det_on,
  input  logic [N_OUT-1:0] mask_lo,
  input  logic [N_OUT-1:0] mask_hi,
  input  logic             ref_lo,
  input  logic             ref_hi,
  input  logic [N_OUT-1:0] out_en_req,
  input  logic             ref_req,
  output logic [N_OUT-1:0] out_en_o,
  output logic             ref_en_o
);
  logic [N_OUT-1:0] mask_act;
  logic             ref_add;

  always_comb begin
    if (!det_on) begin
      mask_act = '1;
      ref_add  = 1'b0;
    end else if (lvl == LVL_HI) begin
      mask_act = mask_hi;
      ref_add  = ref_hi;
    end else begin
      mask_act = mask_lo;
      ref_add  = ref_lo;
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) out_en_o[k] <= 1'b0;
      else     out_en_o[k] <= out_en_req[k] & mask_act[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_en_o <= 1'b0;
    else     ref_en_o <= ref_req | ref_add;
  end
endmodule

// File: rtl/jd_gate.sv
module jd_gate
  import jdg_pkg::*;
#(
  parameter int N_PINS    = 3,
  parameter int N_OUT     = 4,
  parameter int DB_CYCLES = DEF_DB_CYCLES,
  parameter int SEL_W     = $clog2(N_PINS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [SEL_W-1:0]  det_sel,
  input  logic              det_on,
  input  logic [N_OUT-1:0]  mask_lo,
  input  logic [N_OUT-1:0]  mask_hi,
  input  logic              ref_lo,
  input  logic              ref_hi,
  input  logic [N_OUT-1:0]  out_en_req,
  input  logic              ref_req,
  output logic [N_OUT-1:0]  out_en_o,
  output logic              ref_en_o
);
  logic [N_PINS-1:0] pin_s;
  det_lvl_e          det_lvl;

  jdg_sync #(.N_PINS(N_PINS)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_a (pin_i),
    .pin_s (pin_s)
  );

  jdg_debounce #(
    .N_PINS    (N_PINS),
    .SEL_W     (SEL_W),
    .DB_CYCLES (DB_CYCLES)
  ) u_deb (
    .clk   (clk),
    .rst   (rst),
    .pin_s (pin_s),
    .sel   (det_sel),
    .lvl_o (det_lvl)
  );

  jdg_gate_out #(.N_OUT(N_OUT)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .lvl        (det_lvl),
    .det_on     (det_on),
    .mask_lo    (mask_lo),
    .mask_hi    (mask_hi),
    .ref_lo     (ref_lo),
    .ref_hi     (ref_hi),
    .out_en_req (out_en_req),
    .ref_req    (ref_req),
    .out_en_o   (out_en_o),
    .ref_en_o   (ref_en_o)
  );
endmodule

// File: rtl/jd_gate_chk.sv
module jd_gate_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             det_on,
  input logic [N_OUT-1:0] out_en_req,
  input logic             ref_req,
  input logic [N_OUT-1:0] out_en_o,
  input logic             ref_en_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (out_en_o == '0) && !ref_en_o);

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !det_on |=> (out_en_o == $past(out_en_req)) && (ref_en_o == $past(ref_req)));

  // R5
  no_unrequested_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_en_o & ~$past(out_en_req)) == '0));

  // R7
  ref_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ref_req |=> ref_en_o);
endmodule

bind jd_gate jd_gate_chk #(.N_OUT(N_OUT)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .det_on     (det_on),
  .out_en_req (out_en_req),
  .ref_req    (ref_req),
  .out_en_o   (out_en_o),
  .ref_en_o   (ref_en_o)
);

// File: tb/jd_gate_test.sv
module jd_gate_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] pin_i = '0;
  logic [1:0] det_sel = '0;
  logic       det_on = 1'b0;
  logic [3:0] mask_lo = '0, mask_hi = '0;
  logic       ref_lo = 1'b0, ref_hi = 1'b0;
  logic [3:0] out_en_req = '0;
  logic       ref_req = 1'b0;
  logic [3:0] out_en_o;
  logic       ref_en_o;

  int checks = 0;
  int failures = 0;

  jd_gate uut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .det_sel(det_sel), .det_on(det_on),
    .mask_lo(mask_lo), .mask_hi(mask_hi), .ref_lo(ref_lo), .ref_hi(ref_hi),
    .out_en_req(out_en_req), .ref_req(ref_req),
    .out_en_o(out_en_o), .ref_en_o(ref_en_o)
  );

  always #10 clk = ~clk;

  function automatic logic sel_level(logic [1:0] s, logic [2:0] p);
    if (s == 2'b11) return 1'b0;
    return p[s];
  endfunction

  function automatic logic [4:0] expect_out(logic on, logic lvl, logic [3:0] req,
                                            logic rq, logic [3:0] lo, logic [3:0] hi,
                                            logic rl, logic rh);
    logic [3:0] m;
    logic r;
    if (!on) begin
      m = 4'hF; r = 1'b0;
    end else if (lvl) begin
      m = hi; r = rh;
    end else begin
      m = lo; r = rl;
    end
    return {rq | r, req & m};
  endfunction

  task automatic check(string req_tag, logic [4:0] exp);
    checks++;
    if ({ref_en_o, out_en_o} !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req_tag, {ref_en_o, out_en_o}, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [4:0] e;
    out_en_req = 4'hF; ref_req = 1'b1; pin_i = 3'b111;
    settle(3);
    // R1 reset clears outputs
    check("R1", 5'b0);
    rst = 1'b0;

    // R2 pass-through one cycle after inputs change
    det_on = 1'b0; mask_lo = 4'h0; mask_hi = 4'h0; ref_lo = 1'b1;
    out_en_req = 4'b1010; ref_req = 1'b0;
    settle(1);
    check("R2", 5'b01010);

    // R5 level 0 via pin0 (reset left level 0, pin now 0)
    pin_i = 3'b000; det_sel = 2'b00; det_on = 1'b1;
    mask_lo = 4'b0110; mask_hi = 4'b1001; ref_lo = 1'b0; ref_hi = 1'b1;
    out_en_req = 4'hF; ref_req = 1'b0;
    settle(12);
    check("R5", 5'b00110);

    // R9 still old 3 cycles after pin rises; R6 and R7 after settling
    pin_i = 3'b001;
    settle(3);
    check("R9", 5'b00110);
    settle(10);
    check("R6", 5'b11001);
    check("R7", 5'b11001);

    // R3 select pin2 (low) -> level 0
    det_sel = 2'b10; pin_i = 3'b011;
    settle(12);
    check("R3", 5'b00110);
    // R3 select pin1 (high) -> level 1
    det_sel = 2'b01;
    settle(12);
    check("R3", 5'b11001);

    // R4 reserved select with all pins high -> level 0
    pin_i = 3'b111; det_sel = 2'b11;
    settle(12);
    check("R4", 5'b00110);

    // R8 3-cycle pulse ignored on pin0 at level 0
    pin_i = 3'b000; det_sel = 2'b00;
    settle(12);
    pin_i = 3'b001; settle(3); pin_i = 3'b000;
    settle(1); check("R8", 5'b00110);
    settle(3); check("R8", 5'b00110);
    settle(8); check("R8", 5'b00110);
    // R8 4-cycle pulse adopted
    pin_i = 3'b001; settle(4); pin_i = 3'b000;
    settle(4); check("R8", 5'b11001);
    settle(10); check("R8", 5'b00110);

    // R7 both reference bits zero: ref follows request
    ref_lo = 1'b0; ref_hi = 1'b0; ref_req = 1'b0;
    settle(1); check("R7", 5'b00110);
    ref_req = 1'b1;
    settle(1); check("R7", 5'b10110);

    // Random scenarios
    void'($urandom(32'd1234));
    for (int it = 0; it < 60; it++) begin
      pin_i      = 3'($urandom);
      det_sel    = 2'($urandom);
      det_on     = 1'($urandom);
      mask_lo    = 4'($urandom);
      mask_hi    = 4'($urandom);
      ref_lo     = 1'($urandom);
      ref_hi     = 1'($urandom);
      out_en_req = 4'($urandom);
      ref_req    = 1'($urandom);
      settle(12);
      e = expect_out(det_on, sel_level(det_sel, pin_i), out_en_req, ref_req,
                     mask_lo, mask_hi, ref_lo, ref_hi);
      check(det_on ? (sel_level(det_sel, pin_i) ? "R6" : "R5") : "R2", e);
    end

    // R1 reset mid-run
    rst = 1'b1; out_en_req = 4'hF; ref_req = 1'b1;
    settle(2);
    check("R1", 5'b0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule